// File: doc/BRIEF.md
# Four-Phase Instruction Sequencer

This block turns a free-running input clock into a repeating four-slot instruction cycle. It then uses those slots to run a two-stage pipeline in which the next program word is fetched while the current one executes. A rotating set of four mutually exclusive phase strobes marks the slots. The program counter is a byte address that moves forward by one instruction word per cycle. Each fetched word goes through a prefetch register and then into the instruction register, where an attached execute unit decodes it.

The data-memory operand read and destination write strobes are placed at fixed slots of the execute cycle. A clock-out strobe marks the last slot of every cycle. An external execute unit can request a branch together with a target address. The sequencer then discards the sequentially prefetched word and runs a forced NOP, with the execute-valid flag low, while the target word is fetched. Any change of flow therefore costs two instruction cycles, and straight-line code retires one word per cycle.

Top module: `fetch_exec_seq`

## Requirements
- R1: While reset is asserted, and after it is released, the phase vector is 4'b0001 (Q1), the program counter is the reset vector (0 by default), the instruction register holds the NOP word (16'h0000 by default), and exec_valid is 0.
- R2: Exactly one bit of the phase vector is high on every clock. The active bit moves in the order bit0 (Q1), bit1 (Q2), bit2 (Q3), bit3 (Q4) and wraps back to bit0 on each clock, so one instruction cycle is four clocks.
- R3: pmem_addr always equals pc. pc changes only at the clock edge that ends Q4, and its new value is visible from the following Q1. Without a branch it grows by the word size in bytes (2 for 16-bit words).
- R4: The word on pmem_rdata is captured at the end of Q4 of its fetch cycle. It is moved into the instruction register at the end of Q1 of the next cycle and held through Q2 to Q4 with exec_valid 1. The word at the reset vector executes in the second instruction cycle after reset.
- R5: dm_rd is high only in Q2 and dm_wr only in Q4, and both only while exec_valid is 1.
- R6: clk_out is high during Q4 of every instruction cycle, forced-NOP cycles included, and low in all other phases.
- R7: A branch_req that is high at the end of Q4 while exec_valid is 1 loads branch_target into pc in place of the increment. The word fetched in that cycle is discarded, so the next cycle runs the NOP word with exec_valid 0, and the cycle after it executes the target word.
- R8: branch_req has no effect on pc or on the pipeline when it is high only in Q1, Q2 or Q3, or when exec_valid is 0.
- R9: The byte-within-word bits of a branch target are cleared before it is loaded, so pc always stays word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, one phase per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| pmem_rdata | input | WORD_W | Program-memory read word for pmem_addr |
| branch_req | input | 1 | Change-of-flow request from the execute unit |
| branch_target | input | ADDR_W | Byte address to branch to |
| phase | output | 4 | One-hot phase strobes, bit0 = Q1 ... bit3 = Q4 |
| clk_out | output | 1 | High during Q4 of every instruction cycle |
| pc | output | ADDR_W | Program counter (byte address of word being fetched) |
| pmem_addr | output | ADDR_W | Program-memory address |
| ir | output | WORD_W | Instruction register |
| exec_valid | output | 1 | The word in ir is a real instruction (0 = forced NOP) |
| dm_rd | output | 1 | Data-memory operand read strobe (Q2) |
| dm_wr | output | 1 | Data-memory destination write strobe (Q4) |

## Verification
The bench builds the block with 16-bit words and addresses, the NOP word 16'h0000, the one-hot ring variant of the phase generator, and strobe gating on. With these values the byte step is 2, so a target with bit 0 set exercises the alignment mask. A synthetic program memory returns 16'hC000 OR the address, which keeps every fetched word distinct from the NOP word. That lets each flushed slot and each executed target be identified directly on ir.

// File: rtl/fes_pkg.sv
package fes_pkg;
   // phase slot indices within one instruction cycle
   localparam int PH_Q1 = 0;
   localparam int PH_Q2 = 1;
   localparam int PH_Q3 = 2;
   localparam int PH_Q4 = 3;
   localparam int NUM_PHASES = 4;

   // phase generator implementation choices
   typedef enum int {
      PHASE_BINARY = 0,
      PHASE_RING   = 1
   } phase_style_e;
endpackage

// File: rtl/fes_phase_gen.sv
module fes_phase_gen
   import fes_pkg::*;
#(
   parameter int STYLE = PHASE_BINARY
) (
   input  logic                  clk,
   input  logic                  rst_n,
   output logic [NUM_PHASES-1:0] q
);
   localparam int CNT_W = $clog2(NUM_PHASES);

   generate
      if (STYLE == PHASE_RING) begin : g_ring
         logic [NUM_PHASES-1:0] ring;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ring <= NUM_PHASES'(1);
            else        ring <= {ring[NUM_PHASES-2:0], ring[NUM_PHASES-1]};
         end
         assign q = ring;
      end else if (STYLE == PHASE_BINARY) begin : g_bin
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt <= '0;
            else        cnt <= cnt + CNT_W'(1);
         end
         assign q = NUM_PHASES'(1) << cnt;
      end else begin : g_bad
         $error("fes_phase_gen: unsupported STYLE");
      end
   endgenerate

   AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(q) == 1) else $error("phase not one-hot"); // R2
   AST_PHASE_Q1_TO_Q2: assert property (@(posedge clk) disable iff (!rst_n)
      q[PH_Q1] |=> q[PH_Q2]) else $error("Q1 not followed by Q2"); // R2
   AST_PHASE_Q4_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      q[PH_Q4] |=> q[PH_Q1]) else $error("Q4 not followed by Q1"); // R2
endmodule

// File: rtl/fes_pc_unit.sv
module fes_pc_unit #(
   parameter int                ADDR_W       = 16,
   parameter int                STEP         = 2,
   parameter logic [ADDR_W-1:0] RESET_VECTOR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   input  logic              take,
   input  logic [ADDR_W-1:0] target,
   output logic [ADDR_W-1:0] pc
);
   localparam logic [ADDR_W-1:0] LOW_MASK   = ADDR_W'(STEP - 1);
   localparam logic [ADDR_W-1:0] ALIGN_MASK = ~LOW_MASK;
   localparam logic [ADDR_W-1:0] INC        = ADDR_W'(STEP);

   logic [ADDR_W-1:0] pc_next;

   always_comb begin
      pc_next = pc;
      if (advance) begin
         if (take) pc_next = target & ALIGN_MASK;
         else      pc_next = pc + INC;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc <= RESET_VECTOR;
      else        pc <= pc_next;
   end

   AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(pc)) else $error("pc moved outside Q4 edge"); // R3
   AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !take) |=> pc == $past(pc) + INC) else $error("pc step wrong"); // R3
   AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (pc & LOW_MASK) == '0) else $error("pc misaligned"); // R9
endmodule

// File: rtl/fes_pipe_regs.sv
module fes_pipe_regs #(
   parameter int                WORD_W   = 16,
   parameter logic [WORD_W-1:0] NOP_WORD = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic              load,
   input  logic              flush,
   input  logic [WORD_W-1:0] fetch_word,
   output logic [WORD_W-1:0] ir,
   output logic              exec_valid
);
   logic [WORD_W-1:0] pf_word;
   logic              pf_valid;

   // prefetch stage: captured at the end of the fetch cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pf_word  <= NOP_WORD;
         pf_valid <= 1'b0;
      end else if (capture) begin
         pf_word  <= fetch_word;
         pf_valid <= !flush;
      end
   end

   // execute stage: loaded at the end of Q1
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ir         <= NOP_WORD;
         exec_valid <= 1'b0;
      end else if (load) begin
         ir         <= pf_valid ? pf_word : NOP_WORD;
         exec_valid <= pf_valid;
      end
   end

   AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && flush) |=> !pf_valid) else $error("flushed word kept"); // R7
   AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(ir) && $stable(exec_valid))) else $error("ir changed outside Q1"); // R4
   AST_NOP_WHEN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_valid |-> ir == NOP_WORD) else $error("invalid slot not NOP"); // R7
endmodule

// File: rtl/fetch_exec_seq.sv
module fetch_exec_seq
   import fes_pkg::*;
#(
   parameter int                ADDR_W          = 16,
   parameter int                WORD_W          = 16,
   parameter logic [ADDR_W-1:0] RESET_VECTOR    = '0,
   parameter logic [WORD_W-1:0] NOP_WORD        = '0,
   parameter int                PHASE_STYLE     = PHASE_BINARY,
   parameter bit                GATE_DM_STROBES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] pmem_rdata,
   input  logic              branch_req,
   input  logic [ADDR_W-1:0] branch_target,
   output logic [3:0]        phase,
   output logic              clk_out,
   output logic [ADDR_W-1:0] pc,
   output logic [ADDR_W-1:0] pmem_addr,
   output logic [WORD_W-1:0] ir,
   output logic              exec_valid,
   output logic              dm_rd,
   output logic              dm_wr
);
   localparam int                STEP       = WORD_W / 8;
   localparam logic [ADDR_W-1:0] ALIGN_MASK = ~(ADDR_W'(STEP - 1));

   // elaboration-time parameter checks
   generate
      if (WORD_W < 8 || (WORD_W % 8) != 0) begin : g_chk_word
         $error("fetch_exec_seq: WORD_W must be a nonzero multiple of 8");
      end
      if ((STEP & (STEP - 1)) != 0) begin : g_chk_step
         $error("fetch_exec_seq: word size in bytes must be a power of two");
      end
      if (ADDR_W <= $clog2(STEP) || ADDR_W > 32) begin : g_chk_addr
         $error("fetch_exec_seq: ADDR_W out of range");
      end
      if ((RESET_VECTOR & ~ALIGN_MASK) != '0) begin : g_chk_rv
         $error("fetch_exec_seq: RESET_VECTOR not word aligned");
      end
   endgenerate

   logic [NUM_PHASES-1:0] q;
   logic                  take;

   fes_phase_gen #(.STYLE(PHASE_STYLE)) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .q     (q)
   );

   // branch accepted only at the Q4 edge of a real instruction
   assign take = q[PH_Q4] && branch_req && exec_valid;

   fes_pc_unit #(
      .ADDR_W       (ADDR_W),
      .STEP         (STEP),
      .RESET_VECTOR (RESET_VECTOR)
   ) u_pc (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (q[PH_Q4]),
      .take    (take),
      .target  (branch_target),
      .pc      (pc)
   );

   fes_pipe_regs #(
      .WORD_W   (WORD_W),
      .NOP_WORD (NOP_WORD)
   ) u_pipe (
      .clk        (clk),
      .rst_n      (rst_n),
      .capture    (q[PH_Q4]),
      .load       (q[PH_Q1]),
      .flush      (take),
      .fetch_word (pmem_rdata),
      .ir         (ir),
      .exec_valid (exec_valid)
   );

   assign phase     = q;
   assign pmem_addr = pc;
   assign clk_out   = q[PH_Q4];

   generate
      if (GATE_DM_STROBES) begin : g_gated
         assign dm_rd = q[PH_Q2] && exec_valid;
         assign dm_wr = q[PH_Q4] && exec_valid;
      end else begin : g_raw
         assign dm_rd = q[PH_Q2];
         assign dm_wr = q[PH_Q4];
      end
   endgenerate

   AST_RD_ONLY_Q2: assert property (@(posedge clk) disable iff (!rst_n)
      dm_rd |-> phase[PH_Q2]) else $error("read strobe outside Q2"); // R5
   AST_WR_ONLY_Q4: assert property (@(posedge clk) disable iff (!rst_n)
      dm_wr |-> phase[PH_Q4]) else $error("write strobe outside Q4"); // R5
   AST_BRANCH_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (phase[PH_Q4] && branch_req && exec_valid) |=>
      pc == ($past(branch_target) & ALIGN_MASK)) else $error("branch target not loaded"); // R7
   AST_FORCED_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (phase[PH_Q4] && branch_req && exec_valid) |=> ##1 !exec_valid)
      else $error("no forced NOP after branch"); // R7
   AST_ADDR_FOLLOWS_PC: assert property (@(posedge clk) disable iff (!rst_n)
      pmem_addr == pc) else $error("pmem_addr differs from pc"); // R3
endmodule

// File: tb/sim_fetch_exec_seq.sv
module sim_fetch_exec_seq;
   localparam int AW = 16;
   localparam int WW = 16;
   localparam int NV = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [WW-1:0] pmem_rdata;
   logic          branch_req = 1'b0;
   logic [AW-1:0] branch_target = '0;
   logic [3:0]    phase;
   logic          clk_out;
   logic [AW-1:0] pc;
   logic [AW-1:0] pmem_addr;
   logic [WW-1:0] ir;
   logic          exec_valid;
   logic          dm_rd;
   logic          dm_wr;

   int  checks = 0;
   int  errors = 0;
   bit  done   = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   // synthetic program memory: every word differs from the NOP word
   assign pmem_rdata = 16'hC000 | pmem_addr;

   fetch_exec_seq #(
      .ADDR_W          (AW),
      .WORD_W          (WW),
      .RESET_VECTOR    (16'h0000),
      .NOP_WORD        (16'h0000),
      .PHASE_STYLE     (1),
      .GATE_DM_STROBES (1'b1)
   ) u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .pmem_rdata    (pmem_rdata),
      .branch_req    (branch_req),
      .branch_target (branch_target),
      .phase         (phase),
      .clk_out       (clk_out),
      .pc            (pc),
      .pmem_addr     (pmem_addr),
      .ir            (ir),
      .exec_valid    (exec_valid),
      .dm_rd         (dm_rd),
      .dm_wr         (dm_wr)
   );

   // fields: branch at Q4, pulse in Q2 only, target, expected pc, ir, exec_valid (all seen in Q2)
   localparam logic [50:0] VEC [NV] = '{
      {1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b0},  // c0: NOP before first word
      {1'b0, 1'b0, 16'h0000, 16'h0002, 16'hC000, 1'b1},  // c1: first word executes
      {1'b1, 1'b0, 16'h0040, 16'h0004, 16'hC002, 1'b1},  // c2: branch to 0x40
      {1'b1, 1'b0, 16'h0080, 16'h0040, 16'h0000, 1'b0},  // c3: forced NOP, request ignored
      {1'b0, 1'b0, 16'h0000, 16'h0042, 16'hC040, 1'b1},  // c4: target executes
      {1'b1, 1'b0, 16'h0010, 16'h0044, 16'hC042, 1'b1},  // c5: branch backwards
      {1'b0, 1'b0, 16'h0000, 16'h0010, 16'h0000, 1'b0},  // c6: forced NOP
      {1'b1, 1'b0, 16'h0021, 16'h0012, 16'hC010, 1'b1},  // c7: odd target
      {1'b0, 1'b0, 16'h0000, 16'h0020, 16'h0000, 1'b0},  // c8: aligned to 0x20
      {1'b0, 1'b1, 16'h0060, 16'h0022, 16'hC020, 1'b1},  // c9: early pulse in Q2
      {1'b0, 1'b0, 16'h0000, 16'h0024, 16'hC022, 1'b1}   // c10: sequential continues
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one instruction cycle; entered at the falling edge inside Q1
   task automatic run_cycle(input logic br, input logic early, input logic [AW-1:0] tgt,
                            input logic [AW-1:0] epc, input logic [WW-1:0] eir, input logic ev);
      branch_req = 1'b0;
      chk("R2 phase Q1", phase, 4'b0001);
      chk("R6 clk_out low Q1", clk_out, 1'b0);
      chk("R5 no strobe Q1", {dm_rd, dm_wr}, 2'b00);
      @(negedge clk);
      chk("R2 phase Q2", phase, 4'b0010);
      chk("R3 pc", pc, epc);
      chk("R3 pmem_addr", pmem_addr, epc);
      chk("R4 R7 R9 ir", ir, eir);
      chk("R4 R7 exec_valid", exec_valid, ev);
      chk("R5 dm_rd in Q2", dm_rd, ev);
      chk("R5 dm_wr low Q2", dm_wr, 1'b0);
      if (early) begin
         branch_req    = 1'b1;   // R8: request outside Q4
         branch_target = tgt;
      end
      @(negedge clk);
      branch_req = 1'b0;
      chk("R2 phase Q3", phase, 4'b0100);
      chk("R5 no strobe Q3", {dm_rd, dm_wr}, 2'b00);
      @(negedge clk);
      chk("R2 phase Q4", phase, 4'b1000);
      chk("R6 clk_out Q4", clk_out, 1'b1);
      chk("R5 dm_wr in Q4", dm_wr, ev);
      chk("R3 pc stable to Q4", pc, epc);
      branch_req    = br;
      branch_target = tgt;
      @(negedge clk);
   endtask

   initial begin
      // R1: state held under reset
      repeat (3) @(negedge clk);
      chk("R1 phase in reset", phase, 4'b0001);
      chk("R1 pc in reset", pc, 16'h0000);
      chk("R1 ir in reset", ir, 16'h0000);
      chk("R1 exec_valid in reset", exec_valid, 1'b0);
      rst_n = 1'b1;

      // table walk (R2 to R9)
      for (int k = 0; k < NV; k++) begin
         run_cycle(VEC[k][50], VEC[k][49], VEC[k][48:33], VEC[k][32:17], VEC[k][16:1], VEC[k][0]);
      end

      // directed: reset in the middle of a cycle (R1)
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 phase after mid reset", phase, 4'b0001);
      chk("R1 pc after mid reset", pc, 16'h0000);
      chk("R1 ir after mid reset", ir, 16'h0000);
      chk("R1 exec_valid after mid reset", exec_valid, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      // restart: reset-vector word executes in the second cycle (R4)
      run_cycle(1'b1, 1'b0, 16'h0100, 16'h0000, 16'h0000, 1'b0);  // R8: invalid slot branch ignored
      run_cycle(1'b0, 1'b0, 16'h0000, 16'h0002, 16'hC000, 1'b1);
      run_cycle(1'b0, 1'b0, 16'h0000, 16'h0004, 16'hC002, 1'b1);

      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule